// File: doc/BRIEF.md
# Per-Channel Mean Threshold Binarizer

This block converts one colour frame into a one-bit image. It accepts a stream of pixels, each carrying 8-bit red, green and blue values, with markers for the first and last pixel of a frame. While the frame arrives, the block stores every pixel and keeps a separate intensity histogram for each of the three channels. After the frame ends, it sweeps each histogram and sums each intensity multiplied by its count. A shared-schedule restoring divider then divides each channel sum by the frame's pixel count. The integer quotient is that channel's threshold. The block does not convert the pixels to luma: each channel acts as its own grayscale image.

In the second phase, the block reads the stored frame back in arrival order. It tests each channel value against that channel's threshold, which gives three binary planes. It adds the three bits and emits a 1 when the sum is at least one. In gray mode only the red channel feeds the sum, and the rest of the flow is the same. A single-cycle pulse marks the point where the thresholds become valid. That pulse separates accumulation from output.

Top module: `mean_binarizer`

## Requirements
- R1: After reset, out_valid and thr_ready are 0 and in_ready is 1.
- R2: Each channel threshold equals floor(sum of that channel's values over the frame / pixel count), independent of the other channels, and is presented on thr_r/thr_g/thr_b while thr_ready pulses.
- R3: A channel bit is 1 when the stored value is greater than or equal to that channel's threshold, so a value equal to the threshold counts as foreground.
- R4: In colour mode, out_pix is 1 when at least one of the three channel bits is 1 (sum of bits not less than one) and 0 otherwise.
- R5: In gray mode (gray_mode high on the frame's first pixel), out_pix equals the red channel bit alone; green and blue have no effect on the output.
- R6: thr_ready is high for exactly one cycle per frame, after the frame's last pixel is taken, and out_valid first rises in the cycle after thr_ready.
- R7: The output stream holds exactly one pixel per stored input pixel, in arrival order, with out_last high on the final one only; a one-pixel frame (first and last marker together) is legal.
- R8: in_ready is low from the cycle after the last input pixel until out_last is presented; pixels offered while in_ready is low are ignored.
- R9: Histograms are cleared at each frame start, so a frame's thresholds do not depend on earlier frames.
- R10: A pixel carrying the start marker while a frame is being collected discards the partial frame and starts a new one.
- R11: Pixels after the MAX_PIX-th one in a frame are neither stored nor counted; a dropped pixel carrying the end marker still ends the frame.
- R12: While idle, a valid pixel without the start marker is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gray_mode | input | 1 | Gray mode select, sampled with the first pixel |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | First pixel of frame |
| in_eof | input | 1 | Last pixel of frame |
| in_r | input | DW | Red value |
| in_g | input | DW | Green value |
| in_b | input | DW | Blue value |
| in_ready | output | 1 | Block accepts input pixels |
| thr_ready | output | 1 | One-cycle pulse: thresholds valid |
| thr_r | output | DW | Red threshold |
| thr_g | output | DW | Green threshold |
| thr_b | output | DW | Blue threshold |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 1 | Binary output pixel |
| out_last | output | 1 | Final output pixel of frame |

## Verification
The bench builds the block with DW of 8 and MAX_PIX of 16. With these values a 20-pixel frame reaches the drop rule for oversize frames at small cost. The full 256-bin histogram sweep and the multicycle divide still run on every frame. The small buffer keeps each frame to roughly three hundred cycles. That leaves room for restart, idle-ignore, busy-ignore, gray-mode and one-pixel frames in a single run.

// File: rtl/mean_binarizer.sv
module mean_binarizer #(
  parameter int DW      = 8,
  parameter int MAX_PIX = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gray_mode,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [DW-1:0] in_r,
  input  logic [DW-1:0] in_g,
  input  logic [DW-1:0] in_b,
  output logic          in_ready,
  output logic          thr_ready,
  output logic [DW-1:0] thr_r,
  output logic [DW-1:0] thr_g,
  output logic [DW-1:0] thr_b,
  output logic          out_valid,
  output logic          out_pix,
  output logic          out_last
);
  localparam int NB = 1 << DW;
  localparam int CW = $clog2(MAX_PIX + 1);
  localparam int AW = $clog2(MAX_PIX);
  localparam int SW = DW + CW;
  localparam int KW = $clog2(SW);

  typedef enum logic [2:0] {S_IDLE, S_CAP, S_SWEEP, S_DIV, S_PLAY} state_t;
  state_t state;

  logic [CW-1:0]   hist [3][NB];
  logic [3*DW-1:0] fbuf [MAX_PIX];
  logic [DW-1:0]   pin  [3];
  logic [SW-1:0]   acc  [3];
  logic [CW-1:0]   rem  [3];
  logic [CW:0]     trial[3];
  logic [CW:0]     diff [3];
  logic [2:0]      ge;
  logic [CW-1:0]   cnt, rd;
  logic [DW-1:0]   k;
  logic [KW-1:0]   it;
  logic            gray;
  logic            take, start, pix_ok;
  logic [AW-1:0]   wptr;
  logic [3*DW-1:0] word;
  logic [2:0]      hit;
  logic [1:0]      hsum;

  assign pin[0] = in_r;
  assign pin[1] = in_g;
  assign pin[2] = in_b;

  assign in_ready = (state == S_IDLE) || (state == S_CAP);
  assign take     = in_valid && in_ready;
  assign start    = take && in_sof;
  assign pix_ok   = start || (take && state == S_CAP && cnt < CW'(MAX_PIX));
  assign wptr     = start ? '0 : cnt[AW-1:0];

  assign thr_r = acc[0][DW-1:0];
  assign thr_g = acc[1][DW-1:0];
  assign thr_b = acc[2][DW-1:0];

  always_comb begin
    for (int c = 0; c < 3; c++) begin
      trial[c] = {rem[c], acc[c][SW-1]};
      diff[c]  = trial[c] - {1'b0, cnt};
      ge[c]    = trial[c] >= {1'b0, cnt};
    end
  end

  always_comb begin
    word   = fbuf[rd[AW-1:0]];
    hit[0] = word[3*DW-1 -: DW] >= thr_r;
    hit[1] = word[2*DW-1 -: DW] >= thr_g;
    hit[2] = word[DW-1:0]       >= thr_b;
    hsum   = {1'b0, hit[0]} + (gray ? 2'd0 : {1'b0, hit[1]}) + (gray ? 2'd0 : {1'b0, hit[2]});
  end

  always_ff @(posedge clk) begin
    if (start)
      for (int c = 0; c < 3; c++)
        for (int b = 0; b < NB; b++)
          hist[c][b] <= '0;
    if (pix_ok) begin
      for (int c = 0; c < 3; c++)
        hist[c][pin[c]] <= start ? CW'(1) : hist[c][pin[c]] + 1'b1;
      fbuf[wptr] <= {in_r, in_g, in_b};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      rd        <= '0;
      k         <= '0;
      it        <= '0;
      gray      <= 1'b0;
      thr_ready <= 1'b0;
      out_valid <= 1'b0;
      out_pix   <= 1'b0;
      out_last  <= 1'b0;
      for (int c = 0; c < 3; c++) begin
        acc[c] <= '0;
        rem[c] <= '0;
      end
    end else begin
      thr_ready <= 1'b0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      case (state)
        S_IDLE, S_CAP: begin
          if (start) begin
            gray  <= gray_mode;
            cnt   <= CW'(1);
            k     <= '0;
            state <= in_eof ? S_SWEEP : S_CAP;
            for (int c = 0; c < 3; c++) acc[c] <= '0;
          end else if (take && state == S_CAP) begin
            if (cnt < CW'(MAX_PIX)) cnt <= cnt + 1'b1;
            if (in_eof) state <= S_SWEEP;
          end
        end
        S_SWEEP: begin
          for (int c = 0; c < 3; c++)
            acc[c] <= acc[c] + SW'(k) * SW'(hist[c][k]);
          k <= k + 1'b1;
          if (k == DW'(NB - 1)) begin
            state <= S_DIV;
            it    <= '0;
            for (int c = 0; c < 3; c++) rem[c] <= '0;
          end
        end
        S_DIV: begin
          for (int c = 0; c < 3; c++) begin
            rem[c] <= ge[c] ? diff[c][CW-1:0] : trial[c][CW-1:0];
            acc[c] <= {acc[c][SW-2:0], ge[c]};
          end
          it <= it + 1'b1;
          if (it == KW'(SW - 1)) begin
            state     <= S_PLAY;
            thr_ready <= 1'b1;
            rd        <= '0;
          end
        end
        S_PLAY: begin
          out_valid <= 1'b1;
          out_pix   <= hsum >= 2'd1;
          out_last  <= rd == cnt - 1'b1;
          rd        <= rd + 1'b1;
          if (rd == cnt - 1'b1) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_THR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) thr_ready |=> !thr_ready); // R6
  AST_OUT_AFTER_THR: assert property (@(posedge clk) disable iff (!rst_n) $rose(out_valid) |-> $past(thr_ready)); // R6
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_last) |-> !in_ready); // R8
  AST_LAST_IN_STREAM: assert property (@(posedge clk) disable iff (!rst_n) out_last |-> out_valid); // R7
  AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $stable({thr_r, thr_g, thr_b})); // R2
  AST_RD_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (state == S_PLAY) |-> (rd < cnt)); // R11
endmodule

// File: tb/mean_binarizer_bench.sv
module mean_binarizer_bench;
  localparam int DW = 8;
  localparam int MP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gray_mode = 1'b0, in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [DW-1:0] in_r = '0, in_g = '0, in_b = '0;
  logic in_ready, thr_ready, out_valid, out_pix, out_last;
  logic [DW-1:0] thr_r, thr_g, thr_b;

  always #2 clk = ~clk;

  mean_binarizer #(.DW(DW), .MAX_PIX(MP)) u_mean_binarizer (
    .clk(clk), .rst_n(rst_n), .gray_mode(gray_mode), .in_valid(in_valid),
    .in_sof(in_sof), .in_eof(in_eof), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .in_ready(in_ready), .thr_ready(thr_ready), .thr_r(thr_r), .thr_g(thr_g),
    .thr_b(thr_b), .out_valid(out_valid), .out_pix(out_pix), .out_last(out_last));

  int tests = 0, fails = 0;
  int fr [32], fg [32], fb [32];
  int got [64];
  int nout, thr_seen, order_err, rdy_err, last_err, done;
  int cap_r, cap_g, cap_b;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (thr_ready) begin
        thr_seen++;
        cap_r = thr_r; cap_g = thr_g; cap_b = thr_b;
      end
      if (out_valid) begin
        if (thr_seen == 0) order_err++;
        if (!out_last && in_ready) rdy_err++;
        if (nout < 64) got[nout] = out_pix;
        nout++;
        if (out_last) done = 1;
      end else if (out_last) last_err++;
    end
  end

  task automatic px(input int r, input int g, input int b, input bit sof, input bit eof);
    @(negedge clk);
    in_valid = 1'b1; in_sof = sof; in_eof = eof;
    in_r = DW'(r); in_g = DW'(g); in_b = DW'(b);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic run_frame(input int nsend, input bit gray, input bit inject, input string tag);
    int n, sr, sg, sb, er, eg, eb, busy_seen;
    n = nsend < MP ? nsend : MP;
    nout = 0; thr_seen = 0; order_err = 0; rdy_err = 0; last_err = 0; done = 0;
    busy_seen = 0;
    gray_mode = gray;
    for (int i = 0; i < nsend; i++) px(fr[i], fg[i], fb[i], i == 0, i == nsend - 1);
    idle();
    gray_mode = ~gray;
    while (done == 0) begin
      @(negedge clk);
      if (!in_ready) busy_seen++;
      if (inject && !in_ready) begin
        in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1;
        in_r = 8'hFF; in_g = 8'hFF; in_b = 8'hFF;
      end else begin
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      end
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (3) @(negedge clk);
    sr = 0; sg = 0; sb = 0;
    for (int i = 0; i < n; i++) begin sr += fr[i]; sg += fg[i]; sb += fb[i]; end
    er = sr / n; eg = sg / n; eb = sb / n;
    chk(cap_r == er, {"R2 thr_r ", tag}, cap_r, er);
    chk(cap_g == eg, {"R2 thr_g ", tag}, cap_g, eg);
    chk(cap_b == eb, {"R2 thr_b ", tag}, cap_b, eb);
    chk(thr_seen == 1, {"R6 pulse count ", tag}, thr_seen, 1);
    chk(order_err == 0, {"R6 output before thr_ready ", tag}, order_err, 0);
    chk(nout == n, {"R7 output count ", tag}, nout, n);
    chk(last_err == 0, {"R7 stray last ", tag}, last_err, 0);
    chk(rdy_err == 0 && busy_seen > 0, {"R8 in_ready low while busy ", tag}, rdy_err, 0);
    for (int i = 0; i < n && i < nout; i++) begin
      int br, bg, bb, e;
      br = fr[i] >= er; bg = fg[i] >= eg; bb = fb[i] >= eb;
      e = gray ? br : ((br + bg + bb) >= 1);
      chk(got[i] == e, gray ? {"R5 gray pixel ", tag} : {"R3/R4 colour pixel ", tag}, got[i], e);
    end
  endtask

  task automatic t_reset();
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(thr_ready == 0, "R1 thr_ready", thr_ready, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic load4();
    fr[0] = 0;   fr[1] = 0; fr[2] = 0;  fr[3] = 40;
    fg[0] = 200; fg[1] = 0; fg[2] = 0;  fg[3] = 0;
    fb[0] = 0;   fb[1] = 0; fb[2] = 90; fb[3] = 30;
  endtask

  task automatic t_colour();
    load4();
    run_frame(4, 1'b0, 1'b0, "colour");
    chk(cap_r == 10 && cap_g == 50 && cap_b == 30, "R2 explicit thresholds", cap_r, 10);
    chk(got[0] == 1 && got[1] == 0 && got[2] == 1, "R4 merged plane", got[1], 0);
    chk(got[3] == 1, "R3 value equal to threshold", got[3], 1);
  endtask

  task automatic t_gray();
    load4();
    run_frame(4, 1'b1, 1'b0, "gray");
    chk(got[0] == 0 && got[2] == 0 && got[3] == 1, "R5 red only", got[0], 0);
  endtask

  task automatic t_pattern();
    for (int i = 0; i < 12; i++) begin
      fr[i] = (i * 17) % 256; fg[i] = 255 - i * 9; fb[i] = (i * 53) % 256;
    end
    run_frame(12, 1'b0, 1'b0, "pattern");
  endtask

  task automatic t_clear();
    for (int i = 0; i < 3; i++) begin fr[i] = 5 + i; fg[i] = 250 - i; fb[i] = 128; end
    run_frame(3, 1'b0, 1'b0, "R9 second frame");
  endtask

  task automatic t_restart();
    px(250, 250, 250, 1'b1, 1'b0);
    px(250, 250, 250, 1'b0, 1'b0);
    px(250, 250, 250, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) begin fr[i] = i * 20; fg[i] = 100 - i * 10; fb[i] = i * i; end
    run_frame(5, 1'b0, 1'b0, "R10 restart");
  endtask

  task automatic t_idle_ignore();
    px(255, 255, 255, 1'b0, 1'b1);
    idle();
    repeat (2) @(negedge clk);
    chk(in_ready == 1, "R12 still idle", in_ready, 1);
    for (int i = 0; i < 6; i++) begin fr[i] = 60 + i; fg[i] = i * 40; fb[i] = 3; end
    run_frame(6, 1'b0, 1'b0, "R12 after stray pixel");
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 20; i++) begin
      fr[i] = i < MP ? i * 10 : 255; fg[i] = i < MP ? 200 - i * 5 : 0; fb[i] = i < MP ? 7 * i : 255;
    end
    run_frame(20, 1'b0, 1'b0, "R11 overflow");
  endtask

  task automatic t_busy_ignore();
    for (int i = 0; i < 8; i++) begin fr[i] = i * 30; fg[i] = 15; fb[i] = 240 - i * 30; end
    run_frame(8, 1'b0, 1'b1, "R8 busy inject");
  endtask

  task automatic t_single();
    fr[0] = 77; fg[0] = 3; fb[0] = 199;
    run_frame(1, 1'b0, 1'b0, "R7 single pixel");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R7 watchdog actual=hang expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_colour();
    t_gray();
    t_pattern();
    t_clear();
    t_restart();
    t_idle_ignore();
    t_overflow();
    t_busy_ignore();
    t_single();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule